// File: doc/BRIEF.md
# Descriptor-Chained DMA Command Sequencer

This block is the command engine of one DMA channel. It walks a linked list of 16-byte descriptors in memory. At the command pointer it reads the four descriptor words over a simple word-wide memory port and decodes the command. It then does one of three things:

- It hands a buffer transfer to the attached device through a request/done handshake.
- It carries out a sized word load or store itself.
- It treats the command as a no-op or a stop.

When a command completes, the engine writes the residual count and a snapshot of the channel status back into the descriptor. It then decides whether to raise an interrupt, and either steps to the next descriptor or branches.

The channel is enabled by a level `run` input from the control unit. The same unit supplies:

- a wake pulse that restarts a parked channel;
- a flush pulse;
- four device condition bits;
- three selector bytes for the interrupt, branch and wait decisions.

A descriptor that is not legal kills the channel. The engine then sets the dead flag and raises both the interrupt and `kill`, and it stays parked until `run` is dropped.

Descriptor word layout, byte address offsets, little-endian:

| Offset | Bits 31:16 | Bits 15:0 |
|---|---|---|
| +0 | command | request count |
| +4 | data address (32 bits) | |
| +8 | dependent word (32 bits) | |
| +12 | transfer status | residual count |

Top module: `dma_desc_seq`

## Requirements
- R1: While the channel is inactive, a `cp_load` pulse sets `cmd_ptr` to `cp_value` with bits 3:0 cleared. While the channel is active (`chan_status[11]`), `cp_load` has no effect. The rising edge of `run` sets active, and an active channel fetches the descriptor at `cmd_ptr`.
- R2: Commands sit in command bits 15:12:
  - 0: output-more
  - 1: output-last
  - 2: input-more
  - 3: input-last
  - 4: load-word
  - 5: store-word
  - 6: no-op
  - 7: stop

  For the transfer opcodes 0 to 3, the engine holds `xfer_req` until `xfer_done`. While it waits it drives:
  - `xfer_addr` = data address
  - `xfer_count` = request count
  - `xfer_out` = 1 for opcodes 0 and 1
  - `xfer_last` = 1 for opcodes 1 and 3
  - `xfer_key` = key bits 9:8

  The device's `xfer_resid` becomes the residual count.
- R3: Every command except stop, and except a command that kills the channel, writes the word at +12 back to memory. That word is {`chan_status`, residual count}. `chan_status` is laid out as follows:
  - bit 15: run
  - bit 14: flush
  - bit 13: wake
  - bit 12: dead
  - bit 11: active
  - bit 10: branch-taken
  - bits 3:0: `dev_cond`
  - all other bits: 0

  For a no-op the residual count is the value already held in the descriptor.
- R4: Branch mode is in command bits 3:2. The codes are 0 never, 1 if condition set, 2 if condition clear, 3 always. The condition is `(dev_cond & sel[7:4]) == (sel[3:0] & sel[7:4])`, evaluated with `br_sel`. A taken branch loads `cmd_ptr` from the dependent word with bits 3:0 cleared, and sets branch-taken. Otherwise `cmd_ptr` advances by 16 and branch-taken clears.
- R5: Interrupt mode is in command bits 5:4. It uses the same codes and condition as R4, evaluated with `intr_sel`. When the mode selects it, the completion raises `irq` for one cycle.
- R6: Wait mode is in command bits 1:0. It uses the same codes as R4, evaluated with `wait_sel`. While the wait decision is true, the engine holds the command before write-back, and `cmd_ptr` does not move.
- R7: Stop clears active. It does not move `cmd_ptr`, does not write back and raises no interrupt.
- R8: The key sits in command bits 10:8. The channel is killed in any of these cases:
  - the key is 4;
  - the opcode is above 7;
  - a transfer has a data address of zero;
  - a transfer has a key above 3;
  - a load or store has a key below 5.

  On a kill, dead sets and active clears, `irq` and `kill` pulse together, `cmd_ptr` is unchanged and nothing is written back.
- R9: Load-word and store-word size the access from request count bits 2:0. Bit 2 set gives 4 bytes, otherwise bit 1 set gives 2 bytes, otherwise 1 byte.
- R10: Load-word reads the word containing the data address and places the addressed bytes in the low bytes of the dependent word. The upper bytes of the dependent word are kept. The engine writes the dependent word back at +8 before the status word, and never branches after a load-word.
- R11: Store-word writes the low bytes of the dependent word to the data address through byte enables. It never branches.
- R12: A `flush_req` pulse sets flush. The next status write-back carries that flag, and flush clears when that command completes.
- R13: A `wake_req` pulse has effect only while `run` is high and the channel is not dead. In that case it sets wake and active, and wake clears when the next fetch starts.
- R14: While `run` is low:
  - active and dead are cleared;
  - the engine abandons any command in progress;
  - `mem_req` and `xfer_req` are low.

  After reset, `chan_status` shows only `dev_cond`, `cmd_ptr` is 0, and `irq`, `kill` and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | Channel enable level |
| wake_req | input | 1 | Restart pulse |
| flush_req | input | 1 | Flush pulse |
| dev_cond | input | 4 | Device condition bits |
| intr_sel | input | 8 | Interrupt condition mask [7:4] and value [3:0] |
| br_sel | input | 8 | Branch condition mask and value |
| wait_sel | input | 8 | Wait condition mask and value |
| cp_load | input | 1 | Command pointer load strobe |
| cp_value | input | 32 | Command pointer load value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted, read data valid |
| mem_rdata | input | 32 | Read data |
| xfer_req | output | 1 | Buffer transfer request |
| xfer_out | output | 1 | Transfer direction, 1 = to device |
| xfer_last | output | 1 | Final buffer of a packet |
| xfer_addr | output | 32 | Buffer address |
| xfer_count | output | 16 | Requested byte count |
| xfer_key | output | 2 | Stream key |
| xfer_done | input | 1 | Transfer complete |
| xfer_resid | input | 16 | Bytes not moved |
| cmd_ptr | output | 32 | Current command pointer |
| chan_status | output | 16 | Channel status word |
| irq | output | 1 | Interrupt pulse |
| kill | output | 1 | Channel-killed pulse |

## Verification
The assertions assume three things about the surrounding logic:
- The memory side asserts `mem_ack` only while `mem_req` is high.
- The device asserts `xfer_done` only while `xfer_req` is high.
- Load and store addresses are naturally aligned for their size.

The bench's memory and device models answer only a request that is visible at the half-cycle point. Every load and store vector uses an address aligned to its access size. The selector, condition and pointer inputs change only while the engine is parked or in reset. The one exception is `dev_cond` during the wait test, where releasing the stall is the behaviour under test.

// File: rtl/dma_desc_seq.sv
module dma_desc_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        wake_req,
  input  logic        flush_req,
  input  logic [3:0]  dev_cond,
  input  logic [7:0]  intr_sel,
  input  logic [7:0]  br_sel,
  input  logic [7:0]  wait_sel,
  input  logic        cp_load,
  input  logic [31:0] cp_value,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        xfer_req,
  output logic        xfer_out,
  output logic        xfer_last,
  output logic [31:0] xfer_addr,
  output logic [15:0] xfer_count,
  output logic [1:0]  xfer_key,
  input  logic        xfer_done,
  input  logic [15:0] xfer_resid,
  output logic [31:0] cmd_ptr,
  output logic [15:0] chan_status,
  output logic        irq,
  output logic        kill
);
  localparam logic [3:0] OP_LOAD = 4'd4;
  localparam logic [3:0] OP_STORE = 4'd5;
  localparam logic [3:0] OP_STOP = 4'd7;
  localparam logic [2:0] KEY_BAD = 3'd4;
  localparam logic [2:0] KEY_REG = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_EXEC, S_XFER, S_LDST, S_WAIT, S_WB_DEP, S_WB_ST, S_DONE
  } state_t;

  state_t      state;
  logic [1:0]  widx;
  logic [31:0] cp;
  logic [15:0] d_req, d_cmd, d_res;
  logic [31:0] d_addr, d_dep;
  logic        run_q, active, dead, bt, wake, flush, irq_r, kill_r;

  function automatic logic decide(input logic [1:0] mode, input logic [7:0] sel,
                                  input logic [3:0] dev);
    logic c;
    c = ((dev & sel[7:4]) == (sel[3:0] & sel[7:4]));
    case (mode)
      2'd0: decide = 1'b0;
      2'd1: decide = c;
      2'd2: decide = !c;
      default: decide = 1'b1;
    endcase
  endfunction

  wire [3:0] op     = d_cmd[15:12];
  wire [2:0] key    = d_cmd[10:8];
  wire       is_xfr = (op <= 4'd3);
  wire       is_ls  = (op == OP_LOAD) || (op == OP_STORE);
  wire       bad    = (key == KEY_BAD) || (op > OP_STOP) ||
                      (is_xfr && ((d_addr == 32'd0) || (key > 3'd3))) ||
                      (is_ls && (key < KEY_REG));

  wire [3:0]  be_base = d_req[2] ? 4'hF : (d_req[1] ? 4'h3 : 4'h1);
  wire [31:0] bmask   = d_req[2] ? 32'hFFFF_FFFF : (d_req[1] ? 32'h0000_FFFF : 32'h0000_00FF);
  wire [4:0]  bsh     = {d_addr[1:0], 3'b000};
  wire [31:0] ld_val  = (d_dep & ~bmask) | ((mem_rdata >> bsh) & bmask);

  assign chan_status = {run, flush, wake, dead, active, bt, 6'b0, dev_cond};
  assign cmd_ptr     = cp;
  assign irq         = irq_r;
  assign kill        = kill_r;
  assign xfer_req    = (state == S_XFER);
  assign xfer_out    = !op[1];
  assign xfer_last   = op[0];
  assign xfer_addr   = d_addr;
  assign xfer_count  = d_req;
  assign xfer_key    = key[1:0];

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = 32'd0;
    mem_be    = 4'hF;
    mem_wdata = 32'd0;
    case (state)
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = cp + {28'd0, widx, 2'b00};
      end
      S_LDST: begin
        mem_req   = 1'b1;
        mem_we    = (op == OP_STORE);
        mem_addr  = {d_addr[31:2], 2'b00};
        mem_be    = be_base << d_addr[1:0];
        mem_wdata = d_dep << bsh;
      end
      S_WB_DEP: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cp + 32'd8;
        mem_wdata = d_dep;
      end
      S_WB_ST: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cp + 32'd12;
        mem_wdata = {chan_status, d_res};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      widx   <= 2'd0;
      cp     <= 32'd0;
      d_req  <= 16'd0;
      d_cmd  <= 16'd0;
      d_res  <= 16'd0;
      d_addr <= 32'd0;
      d_dep  <= 32'd0;
      run_q  <= 1'b0;
      active <= 1'b0;
      dead   <= 1'b0;
      bt     <= 1'b0;
      wake   <= 1'b0;
      flush  <= 1'b0;
      irq_r  <= 1'b0;
      kill_r <= 1'b0;
    end else begin
      irq_r <= 1'b0;
      kill_r <= 1'b0;
      run_q <= run;
      if (cp_load && !active) cp <= {cp_value[31:4], 4'b0000};
      if (!run) begin
        active <= 1'b0;
        dead   <= 1'b0;
        state  <= S_IDLE;
      end else begin
        if (!run_q) active <= 1'b1;
        if (wake_req && !dead) begin
          wake   <= 1'b1;
          active <= 1'b1;
        end
        case (state)
          S_IDLE: if (active && !dead) begin
            state <= S_FETCH;
            widx  <= 2'd0;
            wake  <= 1'b0;
          end
          S_FETCH: if (mem_ack) begin
            case (widx)
              2'd0: begin d_req <= mem_rdata[15:0]; d_cmd <= mem_rdata[31:16]; end
              2'd1: d_addr <= mem_rdata;
              2'd2: d_dep <= mem_rdata;
              default: d_res <= mem_rdata[15:0];
            endcase
            widx <= widx + 2'd1;
            if (widx == 2'd3) state <= S_EXEC;
          end
          S_EXEC: begin
            if (bad) begin
              dead   <= 1'b1;
              active <= 1'b0;
              irq_r  <= 1'b1;
              kill_r <= 1'b1;
              state  <= S_IDLE;
            end else if (op == OP_STOP) begin
              active <= 1'b0;
              state  <= S_IDLE;
            end else if (is_xfr) state <= S_XFER;
            else if (is_ls) state <= S_LDST;
            else state <= S_WAIT;
          end
          S_XFER: if (xfer_done) begin
            d_res <= xfer_resid;
            state <= S_WAIT;
          end
          S_LDST: if (mem_ack) begin
            if (op == OP_LOAD) d_dep <= ld_val;
            state <= S_WAIT;
          end
          S_WAIT: if (!decide(d_cmd[1:0], wait_sel, dev_cond))
            state <= (op == OP_LOAD) ? S_WB_DEP : S_WB_ST;
          S_WB_DEP: if (mem_ack) state <= S_WB_ST;
          S_WB_ST:  if (mem_ack) state <= S_DONE;
          S_DONE: begin
            flush <= 1'b0;
            if (decide(d_cmd[5:4], intr_sel, dev_cond)) irq_r <= 1'b1;
            if (!is_ls && decide(d_cmd[3:2], br_sel, dev_cond)) begin
              cp <= {d_dep[31:4], 4'b0000};
              bt <= 1'b1;
            end else begin
              cp <= cp + 32'd16;
              bt <= 1'b0;
            end
            state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
      if (flush_req) flush <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_desc_seq_chk.sv
module dma_desc_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        mem_req,
  input logic        xfer_req,
  input logic        xfer_done,
  input logic [31:0] xfer_addr,
  input logic [15:0] xfer_count,
  input logic [31:0] cmd_ptr,
  input logic [15:0] chan_status,
  input logic        irq,
  input logic        kill
);
  AST_KILL_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> (chan_status[12] && !chan_status[11])); // R8
  AST_KILL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> irq); // R8
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && xfer_req)); // R2
  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_done && run) |=> (xfer_req && $stable(xfer_addr) && $stable(xfer_count))); // R2
  AST_RUN_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!mem_req && !xfer_req && !chan_status[11] && !chan_status[12])); // R14
  AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |=> $stable(cmd_ptr)); // R1
endmodule

bind dma_desc_seq dma_desc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .mem_req(mem_req), .xfer_req(xfer_req),
  .xfer_done(xfer_done), .xfer_addr(xfer_addr), .xfer_count(xfer_count),
  .cmd_ptr(cmd_ptr), .chan_status(chan_status), .irq(irq), .kill(kill)
);

// File: tb/dma_desc_seq_test.sv
`timescale 1ns/1ps
module dma_desc_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, wake_req = 1'b0, flush_req = 1'b0, cp_load = 1'b0;
  logic [3:0] dev_cond = 4'd0;
  logic [7:0] intr_sel = 8'd0, br_sel = 8'd0, wait_sel = 8'd0;
  logic [31:0] cp_value = 32'd0;
  logic mem_req, mem_we, mem_ack, xfer_req, xfer_out, xfer_last, xfer_done, irq, kill;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, xfer_addr, cmd_ptr;
  logic [3:0] mem_be;
  logic [15:0] xfer_count, xfer_resid, chan_status;
  logic [1:0] xfer_key;

  always #2.5 clk = ~clk;

  dma_desc_seq uut (.*);

  logic [31:0] mem [0:255];
  logic        tb_wr = 1'b0;
  logic [31:0] tb_waddr = 32'd0, tb_wdata = 32'd0;
  logic        dev_hold = 1'b0;
  int          irq_total = 0, kill_total = 0;
  int          checks = 0, failures = 0;

  initial begin
    mem_ack = 1'b0; mem_rdata = 32'd0; xfer_done = 1'b0; xfer_resid = 16'd5;
  end

  always @(negedge clk) begin
    if (tb_wr) mem[tb_waddr[9:2]] = tb_wdata;
    mem_ack = 1'b0;
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] = mem_wdata[8*b +: 8];
      end else mem_rdata = mem[mem_addr[9:2]];
      mem_ack = 1'b1;
    end
    xfer_done = xfer_req && !dev_hold;
    if (irq) irq_total++;
    if (kill) kill_total++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    tb_waddr = a; tb_wdata = d; tb_wr = 1'b1;
    tick(1);
    tb_wr = 1'b0;
  endtask

  task automatic setup(input logic [15:0] cmd, input logic [15:0] req,
                       input logic [31:0] addr, input logic [31:0] dep);
    run = 1'b0; rst_n = 1'b0;
    poke(32'h100, {cmd, req});
    poke(32'h104, addr);
    poke(32'h108, dep);
    poke(32'h10C, 32'd0);
    poke(32'h110, 32'h7000_0000);
    poke(32'h120, 32'h7000_0000);
    poke(32'h200, 32'h7000_0000);
    poke(32'h380, 32'hA1B2_C3D4);
    poke(32'h390, 32'hFFFF_FFFF);
    rst_n = 1'b1;
    tick(1);
    cp_value = 32'h100; cp_load = 1'b1;
    tick(1);
    cp_load = 1'b0;
  endtask

  task automatic settle();
    int t;
    t = 0;
    tick(3);
    while (chan_status[11] && t < 400) begin tick(1); t++; end
    if (t >= 400) chk("watchdog settle", 32'd1, 32'd0);
    tick(2);
  endtask

  typedef struct packed {
    logic [15:0] cmd;
    logic [15:0] req;
    logic [31:0] addr;
    logic [31:0] dep;
    logic [3:0]  dev;
    logic [7:0]  isel;
    logic [7:0]  bsel;
    logic [31:0] ptr;
    logic [3:0]  nirq;
    logic        dead;
    logic        bt;
    logic [31:0] caddr;
    logic [31:0] cval;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [0:NV-1] = '{
    '{16'h0000, 16'h0008, 32'h300, 32'h0,      4'h0, 8'h00, 8'h00, 32'h110, 4'd0, 1'b0, 1'b0, 32'h10C, 32'h8800_0005},
    '{16'h303C, 16'h0008, 32'h300, 32'h207,    4'h0, 8'h00, 8'h00, 32'h200, 4'd1, 1'b0, 1'b1, 32'h10C, 32'h8800_0005},
    '{16'h1300, 16'h0010, 32'h304, 32'h0,      4'h0, 8'h00, 8'h00, 32'h110, 4'd0, 1'b0, 1'b0, 32'h10C, 32'h8800_0005},
    '{16'h6010, 16'h0000, 32'h0,   32'h0,      4'h1, 8'h11, 8'h00, 32'h110, 4'd1, 1'b0, 1'b0, 32'h10C, 32'h8801_0000},
    '{16'h6020, 16'h0000, 32'h0,   32'h0,      4'h1, 8'h11, 8'h00, 32'h110, 4'd0, 1'b0, 1'b0, 32'h10C, 32'h8801_0000},
    '{16'h6008, 16'h0000, 32'h0,   32'h200,    4'h0, 8'h00, 8'h11, 32'h200, 4'd0, 1'b0, 1'b1, 32'h10C, 32'h8800_0000},
    '{16'h6004, 16'h0000, 32'h0,   32'h200,    4'h0, 8'h00, 8'h11, 32'h110, 4'd0, 1'b0, 1'b0, 32'h10C, 32'h8800_0000},
    '{16'h6004, 16'h0000, 32'h0,   32'h200,    4'h0, 8'h00, 8'h0F, 32'h200, 4'd0, 1'b0, 1'b1, 32'h10C, 32'h8800_0000},
    '{16'h0400, 16'h0008, 32'h300, 32'h0,      4'h0, 8'h00, 8'h00, 32'h100, 4'd1, 1'b1, 1'b0, 32'h10C, 32'h0},
    '{16'h0000, 16'h0008, 32'h0,   32'h0,      4'h0, 8'h00, 8'h00, 32'h100, 4'd1, 1'b1, 1'b0, 32'h10C, 32'h0},
    '{16'h2500, 16'h0008, 32'h300, 32'h0,      4'h0, 8'h00, 8'h00, 32'h100, 4'd1, 1'b1, 1'b0, 32'h10C, 32'h0},
    '{16'h4304, 16'h0004, 32'h380, 32'h0,      4'h0, 8'h00, 8'h00, 32'h100, 4'd1, 1'b1, 1'b0, 32'h10C, 32'h0},
    '{16'h9000, 16'h0000, 32'h300, 32'h0,      4'h0, 8'h00, 8'h00, 32'h100, 4'd1, 1'b1, 1'b0, 32'h10C, 32'h0},
    '{16'h463C, 16'h0004, 32'h380, 32'h200,    4'h0, 8'h00, 8'h00, 32'h110, 4'd1, 1'b0, 1'b0, 32'h108, 32'hA1B2_C3D4},
    '{16'h4600, 16'h0002, 32'h382, 32'h200,    4'h0, 8'h00, 8'h00, 32'h110, 4'd0, 1'b0, 1'b0, 32'h108, 32'h0000_A1B2},
    '{16'h4600, 16'h0009, 32'h381, 32'h200,    4'h0, 8'h00, 8'h00, 32'h110, 4'd0, 1'b0, 1'b0, 32'h108, 32'h0000_02C3},
    '{16'h560C, 16'h0006, 32'h390, 32'h1122_3344, 4'h0, 8'h00, 8'h00, 32'h110, 4'd0, 1'b0, 1'b0, 32'h390, 32'h1122_3344},
    '{16'h5600, 16'h0002, 32'h392, 32'h0000_5566, 4'h0, 8'h00, 8'h00, 32'h110, 4'd0, 1'b0, 1'b0, 32'h390, 32'h5566_FFFF},
    '{16'h5600, 16'h0001, 32'h393, 32'h0000_0077, 4'h0, 8'h00, 8'h00, 32'h110, 4'd0, 1'b0, 1'b0, 32'h390, 32'h77FF_FFFF},
    '{16'h7000, 16'h0000, 32'h0,   32'h0,      4'h0, 8'h00, 8'h00, 32'h100, 4'd0, 1'b0, 1'b0, 32'h10C, 32'h0}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int i0, k0;
    tick(2);
    // R14 reset state
    chk("R14 status", {16'd0, chan_status}, 32'd0);
    chk("R14 ptr", cmd_ptr, 32'd0);
    chk("R14 outputs", {28'd0, mem_req, xfer_req, irq, kill}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      dev_cond = VECS[v].dev; intr_sel = VECS[v].isel; br_sel = VECS[v].bsel; wait_sel = 8'd0;
      setup(VECS[v].cmd, VECS[v].req, VECS[v].addr, VECS[v].dep);
      i0 = irq_total; k0 = kill_total;
      run = 1'b1;
      settle();
      // R2 R3 R4 R5 R7 R8 R9 R10 R11 per vector
      chk($sformatf("R4 R7 ptr v%0d", v), cmd_ptr, VECS[v].ptr);
      chk($sformatf("R5 R8 irq count v%0d", v), irq_total - i0, {28'd0, VECS[v].nirq});
      chk($sformatf("R8 dead v%0d", v), {31'd0, chan_status[12]}, {31'd0, VECS[v].dead});
      chk($sformatf("R8 kill v%0d", v), kill_total - k0, {31'd0, VECS[v].dead});
      chk($sformatf("R4 bt v%0d", v), {31'd0, chan_status[10]}, {31'd0, VECS[v].bt});
      chk($sformatf("R3 R9 R10 R11 mem v%0d", v), mem[VECS[v].caddr[9:2]], VECS[v].cval);
      run = 1'b0;
      tick(2);
    end

    // R2 R1 R12: held transfer, pointer load ignored, flush carried into write-back
    dev_cond = 4'd0; intr_sel = 8'd0; br_sel = 8'd0; wait_sel = 8'd0;
    setup(16'h1200, 16'h0040, 32'h300, 32'h0);
    dev_hold = 1'b1;
    run = 1'b1;
    tick(10);
    chk("R2 xfer_req", {31'd0, xfer_req}, 32'd1);
    chk("R2 xfer_out", {31'd0, xfer_out}, 32'd1);
    chk("R2 xfer_last", {31'd0, xfer_last}, 32'd1);
    chk("R2 xfer_addr", xfer_addr, 32'h300);
    chk("R2 xfer_count", {16'd0, xfer_count}, 32'h40);
    chk("R2 xfer_key", {30'd0, xfer_key}, 32'd2);
    cp_value = 32'h240; cp_load = 1'b1;
    tick(1);
    cp_load = 1'b0;
    tick(1);
    chk("R1 cp_load ignored when active", cmd_ptr, 32'h100);
    flush_req = 1'b1;
    tick(1);
    flush_req = 1'b0;
    chk("R12 flush set", {31'd0, chan_status[14]}, 32'd1);
    dev_hold = 1'b0;
    settle();
    chk("R12 flush in write-back", mem[8'h43], 32'hC800_0005);
    chk("R12 flush cleared", {31'd0, chan_status[14]}, 32'd0);
    chk("R3 advance", cmd_ptr, 32'h110);

    // R6 wait stall, then R13 wake
    run = 1'b0;
    dev_cond = 4'd1; wait_sel = 8'h11;
    setup(16'h6001, 16'h0, 32'h0, 32'h0);
    run = 1'b1;
    tick(30);
    chk("R6 stalled ptr", cmd_ptr, 32'h100);
    chk("R6 stalled active", {31'd0, chan_status[11]}, 32'd1);
    dev_cond = 4'd0;
    settle();
    chk("R6 released ptr", cmd_ptr, 32'h110);
    poke(32'h110, 32'h6000_0000);
    wake_req = 1'b1;
    tick(1);
    wake_req = 1'b0;
    chk("R13 wake set", {30'd0, chan_status[13], chan_status[11]}, 32'd3);
    settle();
    chk("R13 wake cleared at fetch", {31'd0, chan_status[13]}, 32'd0);
    chk("R13 wake resumed", cmd_ptr, 32'h120);

    // R13 R14: dead channel ignores wake; run low clears dead and stops requests
    run = 1'b0;
    wait_sel = 8'd0;
    setup(16'h0400, 16'h8, 32'h300, 32'h0);
    run = 1'b1;
    settle();
    chk("R8 dead set", {31'd0, chan_status[12]}, 32'd1);
    wake_req = 1'b1;
    tick(1);
    wake_req = 1'b0;
    tick(1);
    chk("R13 wake ignored when dead", {30'd0, chan_status[13], chan_status[11]}, 32'd0);
    run = 1'b0;
    tick(1);
    chk("R14 run low clears dead", {31'd0, chan_status[12]}, 32'd0);

    // R14 abandon a stalled command
    setup(16'h6003, 16'h0, 32'h0, 32'h0);
    run = 1'b1;
    tick(20);
    chk("R14 stalled active", {31'd0, chan_status[11]}, 32'd1);
    run = 1'b0;
    tick(1);
    chk("R14 abandoned", {29'd0, chan_status[11], mem_req, xfer_req}, 32'd0);

    // R1 alignment of pointer load while inactive
    cp_value = 32'h12F; cp_load = 1'b1;
    tick(1);
    cp_load = 1'b0;
    tick(1);
    chk("R1 aligned load", cmd_ptr, 32'h120);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule